// File: doc/BRIEF.md
# Memory-to-memory DMA stream engine

This block copies a run of elements from one memory region to another. A reader side fetches elements over a 16-bit read port and places them in a shared 8-entry, 16-bit FIFO. A writer side takes them out of the FIFO and stores them over a 16-bit write port. Because the FIFO decouples the two sides, read bursts and write bursts overlap.

Each side is programmed on its own through a load strobe. The strobe captures a start address, an element count, a signed stride, an element size and a direction bit. The writer side may be reloaded with several shorter segments while the reader runs one long one, or the reverse, as long as the element totals agree. Elements are never packed or unpacked: each element read becomes exactly one element written. Both memory ports use a request/acknowledge handshake, and a beat completes in the cycle where request and acknowledge are both high.

Top module: `mdma_stream`

## Requirements
- R1: Data moves only while both `src_en` and `dst_en` are high. While either is low, `rd_req` and `wr_req` stay low and no side state advances.
- R2: A reader loaded with `src_is_write`=1, or a writer loaded with `dst_is_read`=1, drives `cfg_err` high. While `cfg_err` is high, `rd_req` and `wr_req` stay low.
- R3: The size code is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit elements. Code 3 on a loaded side, or different codes on two loaded sides, drives `cfg_err` high.
- R4: A 16-bit element is one beat on each port. The FIFO carries its data unchanged, and it is written with `wr_be`=2'b11.
- R5: For an 8-bit element, the reader takes byte lane `rd_data[15:8]` when the address bit 0 is 1, and `rd_data[7:0]` otherwise. The writer drives that byte on both lanes of `wr_data`, with `wr_be`=2'b10 for an odd address and 2'b01 for an even one.
- R6: A 32-bit element is two beats, at the element address and then at the address plus 2, low half first. The reader starts an element only when at least two FIFO entries are free. The writer starts an element only when at least two entries are held.
- R7: The FIFO holds 8 entries and keeps their order. The reader stalls when the FIFO has no room for the next element, and the writer stalls when the FIFO is empty.
- R8: After each complete element, the side's address advances by its 16-bit stride, sign-extended, so a negative stride walks downward.
- R9: After reset, `src_done`, `dst_done`, `stream_done` and `cfg_err` are low. A side's done output is high once it has been loaded and its count has reached zero. A new load clears it.
- R10: The reader and the writer may be loaded with different segment counts. `stream_done` is high exactly when the writer is done and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | 1 | Reader side enable |
| src_load | input | 1 | Capture the reader segment parameters |
| src_is_write | input | 1 | Reader direction bit; 1 is illegal |
| src_size | input | 2 | Reader element size code |
| src_addr | input | 32 | Reader start byte address |
| src_count | input | 16 | Reader element count |
| src_stride | input | 16 | Reader signed byte stride |
| dst_en | input | 1 | Writer side enable |
| dst_load | input | 1 | Capture the writer segment parameters |
| dst_is_read | input | 1 | Writer direction bit; 1 is illegal |
| dst_size | input | 2 | Writer element size code |
| dst_addr | input | 32 | Writer start byte address |
| dst_count | input | 16 | Writer element count |
| dst_stride | input | 16 | Writer signed byte stride |
| rd_req | output | 1 | Read beat request |
| rd_addr | output | 32 | Read beat byte address |
| rd_ack | input | 1 | Read beat accepted, data valid |
| rd_data | input | 16 | Read beat data |
| wr_req | output | 1 | Write beat request |
| wr_addr | output | 32 | Write beat byte address |
| wr_data | output | 16 | Write beat data |
| wr_be | output | 2 | Write byte lane enables |
| wr_ack | input | 1 | Write beat accepted |
| src_done | output | 1 | Reader count exhausted |
| dst_done | output | 1 | Writer count exhausted |
| cfg_err | output | 1 | Illegal direction or size setup |
| stream_done | output | 1 | Writer done and FIFO empty |

## Verification
The bound checker watches a set of rules on every clock. Both ports stay quiet when an enable is low or a setup error is present. The FIFO level never overflows or underflows, and it follows the push and pop handshakes. A 32-bit element only starts with two free or two held entries. Byte enables match the element size, and stream completion never coincides with a write. Only the bench's cycle-by-cycle model can show that data and addresses come out correctly. That covers byte lane selection, word halves in order, negative strides, stalls from random acknowledge gaps, segment reloads that end with matching totals, and the exact cycle in which each done flag rises.

// File: rtl/mdma_pkg.sv
// Shared types for the memory-to-memory stream engine.
// Assumes both memory ports are 16 bits wide.
package mdma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } elem_size_e;

    // Number of 16-bit beats (and FIFO entries) one element occupies.
    function automatic logic [1:0] beats_of(elem_size_e s);
        return (s == SZ_WORD) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/mdma_fifo.sv
// Small synchronous FIFO shared by the reader and writer sides.
// Assumes the caller never pushes when full and never pops when empty.
// Push and pop may occur in the same cycle.
module mdma_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   push_data,
    input  logic           pop,
    output logic [W-1:0]   head,
    output logic [LVW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop) begin
                level <= level + 1'b1;
            end else if (pop && !push) begin
                level <= level - 1'b1;
            end
        end
    end

    // Oldest entry is always visible.
    assign head = mem[rd_ptr];

endmodule

// File: rtl/mdma_seq.sv
// Address and count sequencer for one side of the stream.
// A load captures a segment. Each step marks one completed beat.
// A 32-bit element takes two steps, and the address advances by the
// signed stride only after the last beat of an element.
module mdma_seq
    import mdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic [SW-1:0] ld_stride,
    input  elem_size_e    ld_size,
    input  logic          step,
    output logic [AW-1:0] beat_addr,
    output logic          second_beat,
    output elem_size_e    size_q,
    output logic          active,
    output logic          done
);

    logic          loaded;
    logic [AW-1:0] base;
    logic [CW-1:0] cnt;
    logic [SW-1:0] stride_q;
    logic [AW-1:0] stride_ext;

    // Sign-extend the stride to the address width.
    assign stride_ext = {{(AW - SW){stride_q[SW-1]}}, stride_q};

    // Segment capture and per-beat advance; a load wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded      <= 1'b0;
            base        <= '0;
            cnt         <= '0;
            stride_q    <= '0;
            size_q      <= SZ_HALF;
            second_beat <= 1'b0;
        end else if (load) begin
            loaded      <= 1'b1;
            base        <= ld_addr;
            cnt         <= ld_count;
            stride_q    <= ld_stride;
            size_q      <= ld_size;
            second_beat <= 1'b0;
        end else if (step) begin
            if (size_q == SZ_WORD && !second_beat) begin
                second_beat <= 1'b1;
            end else begin
                second_beat <= 1'b0;
                base        <= base + stride_ext;
                cnt         <= cnt - 1'b1;
            end
        end
    end

    // Beat address: the upper half of a word sits 2 bytes up.
    assign beat_addr = base + {{(AW - 2){1'b0}}, second_beat, 1'b0};
    assign active    = loaded && (cnt != '0);
    assign done      = loaded && (cnt == '0);

endmodule

// File: rtl/mdma_stream.sv
// Memory-to-memory stream engine: a reader side fills a shared FIFO
// from a 16-bit read port, and a writer side drains it to a 16-bit
// write port. Assumes single-cycle request/acknowledge beats.
// Descriptor fetch and bus arbitration live elsewhere.
module mdma_stream
    import mdma_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int SW         = 16,
    localparam int BW        = 16,
    localparam int LVW       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_en,
    input  logic          src_load,
    input  logic          src_is_write,
    input  logic [1:0]    src_size,
    input  logic [AW-1:0] src_addr,
    input  logic [CW-1:0] src_count,
    input  logic [SW-1:0] src_stride,
    input  logic          dst_en,
    input  logic          dst_load,
    input  logic          dst_is_read,
    input  logic [1:0]    dst_size,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] dst_count,
    input  logic [SW-1:0] dst_stride,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [BW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [BW-1:0] wr_data,
    output logic [1:0]    wr_be,
    input  logic          wr_ack,
    output logic          src_done,
    output logic          dst_done,
    output logic          cfg_err,
    output logic          stream_done
);

    logic           push;
    logic           pop;
    logic [BW-1:0]  push_data;
    logic [BW-1:0]  head;
    logic [LVW-1:0] fifo_level;
    logic           src_beat;
    logic           dst_beat;
    logic           src_active;
    logic           dst_active;
    elem_size_e     src_size_q;
    elem_size_e     dst_size_q;
    logic           src_loaded;
    logic           dst_loaded;
    logic           src_dir_bad;
    logic           dst_dir_bad;
    logic           run;
    logic           src_fits;
    logic           dst_holds;

    // Reader address and count sequencing.
    mdma_seq #(.AW(AW), .CW(CW), .SW(SW)) u_src_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (src_load),
        .ld_addr    (src_addr),
        .ld_count   (src_count),
        .ld_stride  (src_stride),
        .ld_size    (elem_size_e'(src_size)),
        .step       (push),
        .beat_addr  (rd_addr),
        .second_beat(src_beat),
        .size_q     (src_size_q),
        .active     (src_active),
        .done       (src_done)
    );

    // Writer address and count sequencing.
    mdma_seq #(.AW(AW), .CW(CW), .SW(SW)) u_dst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (dst_load),
        .ld_addr    (dst_addr),
        .ld_count   (dst_count),
        .ld_stride  (dst_stride),
        .ld_size    (elem_size_e'(dst_size)),
        .step       (pop),
        .beat_addr  (wr_addr),
        .second_beat(dst_beat),
        .size_q     (dst_size_q),
        .active     (dst_active),
        .done       (dst_done)
    );

    // Shared element FIFO.
    mdma_fifo #(.DEPTH(FIFO_DEPTH), .W(BW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(push_data),
        .pop      (pop),
        .head     (head),
        .level    (fifo_level)
    );

    // Direction bits and loaded markers, captured with each segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_loaded  <= 1'b0;
            dst_loaded  <= 1'b0;
            src_dir_bad <= 1'b0;
            dst_dir_bad <= 1'b0;
        end else begin
            if (src_load) begin
                src_loaded  <= 1'b1;
                src_dir_bad <= src_is_write;
            end
            if (dst_load) begin
                dst_loaded  <= 1'b1;
                dst_dir_bad <= dst_is_read;
            end
        end
    end

    // Setup checks: direction, size encoding, and matching sizes.
    assign cfg_err = (src_loaded && (src_dir_bad || src_size_q == SZ_BAD)) ||
                     (dst_loaded && (dst_dir_bad || dst_size_q == SZ_BAD)) ||
                     (src_loaded && dst_loaded && src_size_q != dst_size_q);

    assign run = src_en && dst_en && !cfg_err;

    // Room and availability for a whole element at its first beat.
    assign src_fits  = ({1'b0, fifo_level} + (LVW + 1)'(beats_of(src_size_q)))
                       <= (LVW + 1)'(FIFO_DEPTH);
    assign dst_holds = fifo_level >= LVW'(beats_of(dst_size_q));

    // Beat requests and completed handshakes.
    assign rd_req = run && src_active && (src_beat || src_fits);
    assign wr_req = run && dst_active && (dst_beat || dst_holds);
    assign push   = rd_req && rd_ack;
    assign pop    = wr_req && wr_ack;

    // Reader lane select: bytes land in the low half of an entry.
    always_comb begin
        if (src_size_q == SZ_BYTE) begin
            push_data = {8'h00, rd_addr[0] ? rd_data[15:8] : rd_data[7:0]};
        end else begin
            push_data = rd_data;
        end
    end

    // Writer lane steering and byte enables.
    always_comb begin
        if (dst_size_q == SZ_BYTE) begin
            wr_data = {head[7:0], head[7:0]};
            wr_be   = wr_addr[0] ? 2'b10 : 2'b01;
        end else begin
            wr_data = head;
            wr_be   = 2'b11;
        end
    end

    assign stream_done = dst_done && (fifo_level == '0);

endmodule

// File: rtl/mdma_stream_chk.sv
// Cycle-by-cycle rule checker for the stream engine, bound to the top.
module mdma_stream_chk #(
    parameter int DEPTH = 8,
    localparam int LVW  = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           src_en,
    input logic           dst_en,
    input logic           rd_req,
    input logic           wr_req,
    input logic           cfg_err,
    input logic           push,
    input logic           pop,
    input logic [LVW-1:0] fifo_level,
    input logic           src_beat,
    input logic           dst_beat,
    input logic [1:0]     src_size_q,
    input logic [1:0]     dst_size_q,
    input logic [1:0]     wr_be,
    input logic           stream_done,
    input logic           dst_done
);

    // R1
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_en && dst_en) |-> !rd_req && !wr_req);

    // R2
    cfg_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !rd_req && !wr_req);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (int'(fifo_level) < DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fifo_level != '0));

    // R7
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fifo_level == LVW'($past(fifo_level) + LVW'($past(push)) - LVW'($past(pop)))));

    // R6
    word_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && src_size_q == 2'd2 && !src_beat) |-> (int'(fifo_level) <= DEPTH - 2));

    // R6
    word_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dst_size_q == 2'd2 && !dst_beat) |-> (fifo_level >= LVW'(2)));

    // R5
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dst_size_q == 2'd0) |-> ($countones(wr_be) == 1));

    // R4
    wide_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dst_size_q != 2'd0) |-> (wr_be == 2'b11));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_done |-> !wr_req && dst_done);

endmodule

bind mdma_stream mdma_stream_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .dst_en     (dst_en),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .cfg_err    (cfg_err),
    .push       (push),
    .pop        (pop),
    .fifo_level (fifo_level),
    .src_beat   (src_beat),
    .dst_beat   (dst_beat),
    .src_size_q (src_size_q),
    .dst_size_q (dst_size_q),
    .wr_be      (wr_be),
    .stream_done(stream_done),
    .dst_done   (dst_done)
);

// File: tb/mdma_stream_bench.sv
// Bench: a behavioural queue model steps alongside the design and is
// compared with every output on every clock.
module mdma_stream_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_en, src_load, src_is_write;
    logic [1:0]  src_size;
    logic [31:0] src_addr;
    logic [15:0] src_count, src_stride;
    logic        dst_en, dst_load, dst_is_read;
    logic [1:0]  dst_size;
    logic [31:0] dst_addr;
    logic [15:0] dst_count, dst_stride;
    logic        rd_req, rd_ack, wr_req, wr_ack;
    logic [31:0] rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;
    logic [1:0]  wr_be;
    logic        src_done, dst_done, cfg_err, stream_done;
    logic        rd_stall, wr_stall;
    int          rd_pct, wr_pct;

    int nchk = 0;
    int nbad = 0;
    int cyc  = 0;
    int dut_writes = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_word(logic [31:0] a);
        return (a[16:1] * 16'd421) ^ 16'h5A3C;
    endfunction

    assign rd_ack  = rd_req & !rd_stall;
    assign wr_ack  = wr_req & !wr_stall;
    assign rd_data = mem_word(rd_addr);

    mdma_stream u_mdma_stream (
        .clk(clk), .rst_n(rst_n),
        .src_en(src_en), .src_load(src_load), .src_is_write(src_is_write),
        .src_size(src_size), .src_addr(src_addr), .src_count(src_count),
        .src_stride(src_stride),
        .dst_en(dst_en), .dst_load(dst_load), .dst_is_read(dst_is_read),
        .dst_size(dst_size), .dst_addr(dst_addr), .dst_count(dst_count),
        .dst_stride(dst_stride),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_ack(wr_ack),
        .src_done(src_done), .dst_done(dst_done), .cfg_err(cfg_err),
        .stream_done(stream_done)
    );

    // ---------------- reference model state ----------------
    logic [31:0] m_sa, m_da;
    int          m_scnt, m_dcnt;
    logic [15:0] m_sst, m_dst;
    logic [1:0]  m_ssz, m_dsz;
    bit          m_sbeat, m_dbeat, m_sl, m_dl, m_swr, m_drd;
    logic [15:0] q[$];

    function automatic bit e_err();
        return (m_sl && (m_swr || m_ssz == 2'd3)) ||
               (m_dl && (m_drd || m_dsz == 2'd3)) ||
               (m_sl && m_dl && m_ssz != m_dsz);
    endfunction

    function automatic bit e_rd_req();
        int need = (m_ssz == 2'd2) ? 2 : 1;
        return src_en && dst_en && !e_err() && m_sl && m_scnt != 0 &&
               (m_sbeat || (DEPTH - q.size()) >= need);
    endfunction

    function automatic bit e_wr_req();
        int need = (m_dsz == 2'd2) ? 2 : 1;
        return src_en && dst_en && !e_err() && m_dl && m_dcnt != 0 &&
               (m_dbeat || q.size() >= need);
    endfunction

    function automatic logic [31:0] e_rd_addr();
        return m_sa + (m_sbeat ? 32'd2 : 32'd0);
    endfunction

    function automatic logic [31:0] e_wr_addr();
        return m_da + (m_dbeat ? 32'd2 : 32'd0);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Model step on each edge, using the inputs held across that edge.
    always @(posedge clk) begin : model_step
        bit          do_push, do_pop;
        logic [15:0] pv;
        logic [31:0] a;
        cyc++;
        if (wr_req && wr_ack) dut_writes++;
        if (!rst_n) begin
            m_sl = 0; m_dl = 0; m_sbeat = 0; m_dbeat = 0;
            m_swr = 0; m_drd = 0; m_scnt = 0; m_dcnt = 0;
            m_sa = 0; m_da = 0; m_ssz = 2'd1; m_dsz = 2'd1;
            q.delete();
        end else begin
            do_push = e_rd_req() && !rd_stall;
            do_pop  = e_wr_req() && !wr_stall;
            a  = e_rd_addr();
            pv = mem_word(a);
            if (m_ssz == 2'd0) pv = {8'h00, a[0] ? pv[15:8] : pv[7:0]};
            if (do_pop) begin
                void'(q.pop_front());
                if (m_dsz == 2'd2 && !m_dbeat) m_dbeat = 1;
                else begin m_dbeat = 0; m_da = m_da + {{16{m_dst[15]}}, m_dst}; m_dcnt--; end
            end
            if (do_push) begin
                q.push_back(pv);
                if (m_ssz == 2'd2 && !m_sbeat) m_sbeat = 1;
                else begin m_sbeat = 0; m_sa = m_sa + {{16{m_sst[15]}}, m_sst}; m_scnt--; end
            end
            if (src_load) begin
                m_sl = 1; m_swr = src_is_write; m_ssz = src_size; m_sa = src_addr;
                m_scnt = src_count; m_sst = src_stride; m_sbeat = 0;
            end
            if (dst_load) begin
                m_dl = 1; m_drd = dst_is_read; m_dsz = dst_size; m_da = dst_addr;
                m_dcnt = dst_count; m_dst = dst_stride; m_dbeat = 0;
            end
        end
    end

    // Mid-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk(rd_req === e_rd_req(), "R1/R7 rd_req", {31'd0, rd_req}, {31'd0, e_rd_req()});
            chk(wr_req === e_wr_req(), "R1/R7 wr_req", {31'd0, wr_req}, {31'd0, e_wr_req()});
            if (e_rd_req())
                chk(rd_addr === e_rd_addr(), "R8 rd_addr", rd_addr, e_rd_addr());
            if (e_wr_req()) begin
                logic [15:0] ed;
                logic [1:0]  eb;
                ed = (m_dsz == 2'd0) ? {q[0][7:0], q[0][7:0]} : q[0];
                eb = (m_dsz != 2'd0) ? 2'b11 : (e_wr_addr() & 1) != 0 ? 2'b10 : 2'b01;
                chk(wr_addr === e_wr_addr(), "R8 wr_addr", wr_addr, e_wr_addr());
                chk(wr_data === ed, "R4/R6 wr_data", {16'd0, wr_data}, {16'd0, ed});
                chk(wr_be === eb, "R5 wr_be", {30'd0, wr_be}, {30'd0, eb});
            end
            chk(src_done === (m_sl && m_scnt == 0), "R9 src_done",
                {31'd0, src_done}, {31'd0, m_sl && m_scnt == 0});
            chk(dst_done === (m_dl && m_dcnt == 0), "R9 dst_done",
                {31'd0, dst_done}, {31'd0, m_dl && m_dcnt == 0});
            chk(cfg_err === e_err(), "R2/R3 cfg_err", {31'd0, cfg_err}, {31'd0, e_err()});
            chk(stream_done === (m_dl && m_dcnt == 0 && q.size() == 0), "R10 stream_done",
                {31'd0, stream_done}, {31'd0, m_dl && m_dcnt == 0 && q.size() == 0});
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired act=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
        src_load = 1'b0;
        dst_load = 1'b0;
        rd_stall = ($urandom_range(99) < rd_pct);
        wr_stall = ($urandom_range(99) < wr_pct);
    endtask

    task automatic load_src(logic [1:0] sz, logic [31:0] a, int n, int st, bit bad);
        src_size = sz; src_addr = a; src_count = 16'(n); src_stride = 16'(st);
        src_is_write = bad; src_load = 1'b1;
    endtask

    task automatic load_dst(logic [1:0] sz, logic [31:0] a, int n, int st, bit bad);
        dst_size = sz; dst_addr = a; dst_count = 16'(n); dst_stride = 16'(st);
        dst_is_read = bad; dst_load = 1'b1;
    endtask

    task automatic wait_stream(int lim);
        int n = 0;
        while (!(stream_done === 1'b1 && src_done === 1'b1) && n < lim) begin
            tick();
            n++;
        end
    endtask

    initial begin
        int w0;
        rst_n = 1'b0; src_en = 1'b0; dst_en = 1'b0;
        src_load = 1'b0; dst_load = 1'b0; src_is_write = 1'b0; dst_is_read = 1'b0;
        src_size = 2'd1; dst_size = 2'd1; src_addr = '0; dst_addr = '0;
        src_count = '0; dst_count = '0; src_stride = '0; dst_stride = '0;
        rd_pct = 0; wr_pct = 0; rd_stall = 1'b0; wr_stall = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R9: reset state
        chk(!src_done && !dst_done && !stream_done, "R9 done after reset",
            {29'd0, src_done, dst_done, stream_done}, 32'd0);
        chk(!cfg_err && !rd_req && !wr_req, "R9 quiet after reset",
            {29'd0, cfg_err, rd_req, wr_req}, 32'd0);

        // R4: 16-bit block, free-running ports
        src_en = 1'b1; dst_en = 1'b1;
        w0 = dut_writes;
        load_src(2'd1, 32'h1000, 20, 2, 0);
        load_dst(2'd1, 32'h8000, 20, 2, 0);
        tick();
        wait_stream(2000);
        chk(dut_writes - w0 == 20, "R4 16-bit write count", dut_writes - w0, 20);

        // R5, R8: bytes, odd start, negative writer stride, random stalls
        rd_pct = 30; wr_pct = 40;
        w0 = dut_writes;
        load_src(2'd0, 32'h2001, 15, 1, 0);
        load_dst(2'd0, 32'h9010, 15, -1, 0);
        tick();
        wait_stream(4000);
        chk(dut_writes - w0 == 15, "R5 byte write count", dut_writes - w0, 15);
        chk(stream_done === 1'b1, "R8 byte stream finished", {31'd0, stream_done}, 1);

        // R6: 32-bit elements, heavy writer stalls
        rd_pct = 10; wr_pct = 70;
        w0 = dut_writes;
        load_src(2'd2, 32'h3000, 10, 4, 0);
        load_dst(2'd2, 32'hA000, 10, -8, 0);
        tick();
        wait_stream(6000);
        chk(dut_writes - w0 == 20, "R6 word beat count", dut_writes - w0, 20);

        // R7: writer fully blocked, reader stops at a full FIFO
        rd_pct = 0; wr_pct = 100;
        load_src(2'd1, 32'h4000, 20, 2, 0);
        load_dst(2'd1, 32'hB000, 20, 2, 0);
        tick();
        repeat (30) tick();
        chk(rd_req === 1'b0, "R7 reader stalls on full FIFO", {31'd0, rd_req}, 0);
        wr_pct = 0;
        wait_stream(2000);
        chk(src_done === 1'b1, "R7 full block drained", {31'd0, src_done}, 1);

        // R1: drop one enable mid-transfer
        w0 = dut_writes;
        load_src(2'd1, 32'h5000, 30, 2, 0);
        load_dst(2'd1, 32'hC000, 30, 2, 0);
        repeat (6) tick();
        dst_en = 1'b0;
        tick();
        for (int i = 0; i < 15; i++) begin
            chk(!rd_req && !wr_req, "R1 idle while disabled",
                {30'd0, rd_req, wr_req}, 0);
            tick();
        end
        dst_en = 1'b1;
        wait_stream(2000);
        chk(dut_writes - w0 == 30, "R1 resumed block count", dut_writes - w0, 30);

        // R2: reader programmed to write
        load_src(2'd1, 32'h6000, 4, 2, 1);
        load_dst(2'd1, 32'hD000, 4, 2, 0);
        tick();
        repeat (10) tick();
        chk(cfg_err === 1'b1 && !rd_req, "R2 reader write flagged",
            {30'd0, cfg_err, rd_req}, 32'd2);
        // R2: writer programmed to read
        load_src(2'd1, 32'h6000, 4, 2, 0);
        load_dst(2'd1, 32'hD000, 4, 2, 1);
        tick();
        repeat (5) tick();
        chk(cfg_err === 1'b1 && !wr_req, "R2 writer read flagged",
            {30'd0, cfg_err, wr_req}, 32'd2);

        // R3: size mismatch, then illegal code
        load_src(2'd1, 32'h6000, 4, 2, 0);
        load_dst(2'd2, 32'hD000, 2, 4, 0);
        tick();
        repeat (3) tick();
        chk(cfg_err === 1'b1 && !rd_req, "R3 size mismatch flagged",
            {30'd0, cfg_err, rd_req}, 32'd2);
        load_src(2'd3, 32'h6000, 4, 2, 0);
        load_dst(2'd3, 32'hD000, 4, 2, 0);
        tick();
        repeat (3) tick();
        chk(cfg_err === 1'b1, "R3 size code 3 flagged", {31'd0, cfg_err}, 1);

        // R10: reader one segment of 12, writer 5 then 7
        rd_pct = 20; wr_pct = 20;
        w0 = dut_writes;
        load_src(2'd1, 32'h7000, 12, 2, 0);
        load_dst(2'd1, 32'hE000, 5, 2, 0);
        tick();
        for (int i = 0; i < 2000 && dst_done !== 1'b1; i++) tick();
        chk(dut_writes - w0 == 5, "R10 first writer segment", dut_writes - w0, 5);
        load_dst(2'd1, 32'hF000, 7, 2, 0);
        tick();
        wait_stream(2000);
        chk(dut_writes - w0 == 12, "R10 segment totals", dut_writes - w0, 12);
        chk(stream_done === 1'b1, "R10 stream done", {31'd0, stream_done}, 1);

        tick();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule